// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a decoded operand specifier into a memory or branch target address. Each cycle it may accept one request. A request carries a 4-bit mode code, the selected base register number with its value, an index register value, a 32-bit immediate, the address of the next instruction, an access-size code, and an optional pair of index bounds. One clock later the unit presents the effective address. For the auto-modifying modes it also presents a base-register update with its enable. For the checked scaled mode it raises a range-violation flag.

All modes share one three-operand adder. The mode decoder only chooses what feeds each of its three inputs. Index scaling is a left shift by the size code. The auto-modify step is the access size in bytes. A fault input presented with the request stops the register update, so the instruction can be reissued with its base unchanged. The register file and memory stay outside the unit. The write-back port is meant to drive a register-file write, and the address is meant to drive a memory port or a load-effective-address result.

Top module: `eagu_top`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `out_valid`, `wb_en` and `bnd_err` are 0.
- R2: A request accepted at a clock edge (`req_valid`=1) appears on the outputs at that edge, with `out_valid`=1. When `req_valid`=0 at an edge, `out_valid` is 0 after it.
- R3: Mode 0 gives `ea` = `imm`. Mode 2 gives `ea` = base. Mode 4 gives `ea` = base + index.
- R4: Mode 1 gives `ea` = `next_pc` + sign-extended `imm[15:0]`. This covers offsets from -32768 to +32767.
- R5: Mode 3 gives base + sign-extended `imm[15:0]`. Mode 5 gives base + index + sign-extended `imm[15:0]`. All sums wrap modulo 2^32.
- R6: When `base_sel` is 0, the base term is 0 whatever `base_val` holds.
- R7: Mode 6 gives `ea` = base + (index << `size_code`). Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R8: Mode 7 (post-increment) gives `ea` = the old base. It also gives `wb_en`=1 and `wb_data` = base + 2^`size_code`.
- R9: Mode 8 (pre-decrement) gives `wb_data` = base - 2^`size_code` and `ea` equal to that new value, with `wb_en`=1.
- R10: Mode 9 computes the same address as mode 6. It sets `bnd_err` when the index, taken as unsigned, is below `bound_lo` or above `bound_hi`. The address is still output, and `wb_en` stays 0. The bounds themselves are legal index values.
- R11: When `fault` is 1 with a request, `wb_en` is 0 for that request. `ea` is still produced.
- R12: Codes 10 to 15 are reserved. They give `ea` = 0, `wb_en` = 0 and `bnd_err` = 0.
- R13: `wb_idx` equals the request's `base_sel`. No write-back is issued when `base_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 5 | Base register number (0 reads as zero) |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| imm | input | 32 | Instruction immediate |
| next_pc | input | 32 | Address of the following instruction |
| size_code | input | 2 | Access size: 1, 2, 4 or 8 bytes |
| bound_lo | input | 32 | Lowest allowed index |
| bound_hi | input | 32 | Highest allowed index |
| fault | input | 1 | Suppress base update for this request |
| out_valid | output | 1 | Outputs hold a result |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base register update enable |
| wb_idx | output | 5 | Register number to update |
| wb_data | output | 32 | Updated base value |
| bnd_err | output | 1 | Index outside bounds |

## Verification
A base update and a fault can land on the same request. The bench provokes this by raising `fault` alongside post-increment and pre-decrement requests, and it judges the result by requiring that the address is still correct while `wb_en` stays low. The same collision arises between auto-modify and the hard-wired zero register, which is exercised by selecting register 0 with both auto-modify modes. Long runs of mixed modes then randomise `fault`, the modes and the bounds against a cycle-accurate reference, so that these coincidences also occur back to back.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
    typedef enum logic [3:0] {
        AM_ABS        = 4'd0,
        AM_PCREL      = 4'd1,
        AM_REGIND     = 4'd2,
        AM_BOFF       = 4'd3,
        AM_BIDX       = 4'd4,
        AM_BIDXOFF    = 4'd5,
        AM_SCALED     = 4'd6,
        AM_POSTINC    = 4'd7,
        AM_PREDEC     = 4'd8,
        AM_SCALED_CHK = 4'd9
    } am_e;
endpackage

// File: rtl/eagu_sext.sv
module eagu_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val,
    output logic [OUT_W-1:0] ext
);
    localparam int PAD_W = OUT_W - IN_W;
    assign ext = {{PAD_W{val[IN_W-1]}}, val};
endmodule

// File: rtl/eagu_scaler.sv
module eagu_scaler #(
    parameter int W    = 32,
    parameter int SZ_W = 2
) (
    input  logic [W-1:0]    idx,
    input  logic [SZ_W-1:0] sh,
    output logic [W-1:0]    scaled,
    output logic [W-1:0]    step
);
    // Scaling uses a shift instead of a multiply, since every size is a power of two.
    assign scaled = idx << sh;
    assign step   = W'(1) << sh;
endmodule

// File: rtl/eagu_bounds.sv
module eagu_bounds #(
    parameter int W      = 32,
    parameter bit ENABLE = 1'b1
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         viol
);
    generate
        if (ENABLE) begin : g_chk
            assign viol = (idx < lo) || (idx > hi);
        end else begin : g_nochk
            logic unused_ok;
            assign unused_ok = ^{idx, lo, hi};
            assign viol = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/eagu_sum3.sv
module eagu_sum3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s
);
    assign s = a + b + c;
endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int RIDX_W    = 5,
    parameter int SIZE_W    = 2,
    parameter bit BOUNDS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        mode,
    input  logic [RIDX_W-1:0] base_sel,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [ADDR_W-1:0] imm,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [ADDR_W-1:0] bound_lo,
    input  logic [ADDR_W-1:0] bound_hi,
    input  logic              fault,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [ADDR_W-1:0] wb_data,
    output logic              bnd_err
);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    am_e               am;
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] idx_scaled;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] term_a, term_b, term_c;
    logic [ADDR_W-1:0] ea_nxt, wb_nxt;
    logic              wants_wb, wants_chk, viol;
    logic              wb_go, err_go;

    assign am       = am_e'(mode);
    assign base_eff = (base_sel == '0) ? ZERO : base_val;

    eagu_sext #(.IN_W(OFF_W), .OUT_W(ADDR_W)) u_sext (
        .val (imm[OFF_W-1:0]),
        .ext (off_ext)
    );

    eagu_scaler #(.W(ADDR_W), .SZ_W(SIZE_W)) u_scale (
        .idx    (index_val),
        .sh     (size_code),
        .scaled (idx_scaled),
        .step   (step)
    );

    eagu_bounds #(.W(ADDR_W), .ENABLE(BOUNDS_EN)) u_bounds (
        .idx  (index_val),
        .lo   (bound_lo),
        .hi   (bound_hi),
        .viol (viol)
    );

    // Operand steering into the shared three-input adder
    always_comb begin
        term_a    = ZERO;
        term_b    = ZERO;
        term_c    = ZERO;
        wants_wb  = 1'b0;
        wants_chk = 1'b0;
        unique case (am)
            AM_ABS:        term_a = imm;
            AM_PCREL: begin
                term_a = next_pc;
                term_c = off_ext;
            end
            AM_REGIND:     term_a = base_eff;
            AM_BOFF: begin
                term_a = base_eff;
                term_c = off_ext;
            end
            AM_BIDX: begin
                term_a = base_eff;
                term_b = index_val;
            end
            AM_BIDXOFF: begin
                term_a = base_eff;
                term_b = index_val;
                term_c = off_ext;
            end
            AM_SCALED: begin
                term_a = base_eff;
                term_b = idx_scaled;
            end
            AM_POSTINC: begin
                term_a   = base_eff;
                wants_wb = 1'b1;
            end
            AM_PREDEC: begin
                term_a   = base_eff;
                term_b   = ZERO - step;
                wants_wb = 1'b1;
            end
            AM_SCALED_CHK: begin
                term_a    = base_eff;
                term_b    = idx_scaled;
                wants_chk = 1'b1;
            end
            default: ;
        endcase
    end

    eagu_sum3 #(.W(ADDR_W)) u_sum (
        .a (term_a),
        .b (term_b),
        .c (term_c),
        .s (ea_nxt)
    );

    assign wb_nxt = (am == AM_PREDEC) ? ea_nxt : (base_eff + step);
    assign err_go = req_valid && wants_chk && viol;
    assign wb_go  = req_valid && wants_wb && !fault && (base_sel != '0) && !err_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            bnd_err   <= 1'b0;
            ea        <= '0;
            wb_idx    <= '0;
            wb_data   <= '0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= wb_go;
            bnd_err   <= err_go;
            if (req_valid) begin
                ea      <= ea_nxt;
                wb_idx  <= base_sel;
                wb_data <= wb_nxt;
            end
        end
    end
endmodule

// File: rtl/eagu_chk.sv
module eagu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  mode,
    input logic [4:0]  base_sel,
    input logic [31:0] base_val,
    input logic        fault,
    input logic        out_valid,
    input logic [31:0] ea,
    input logic        wb_en,
    input logic [31:0] wb_data,
    input logic        bnd_err
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R11
    fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fault) |=> !wb_en);
    // R10
    bnd_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_err |-> !wb_en);
    // R13
    r0_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_sel == 5'd0) |=> !wb_en);
    // R8
    postinc_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 4'd7 && base_sel != 5'd0) |=> (ea == $past(base_val)));
    // R9
    predec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 4'd8 && !fault && base_sel != 5'd0) |=> (wb_en && wb_data == ea));
    // R12
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode >= 4'd10) |=> (!wb_en && !bnd_err && ea == 32'd0));
endmodule

bind eagu_top eagu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode      (mode),
    .base_sel  (base_sel),
    .base_val  (base_val),
    .fault     (fault),
    .out_valid (out_valid),
    .ea        (ea),
    .wb_en     (wb_en),
    .wb_data   (wb_data),
    .bnd_err   (bnd_err)
);

// File: tb/eagu_top_tb.sv
module eagu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [4:0]  base_sel = '0;
    logic [31:0] base_val = '0, index_val = '0, imm = '0, next_pc = '0;
    logic [1:0]  size_code = '0;
    logic [31:0] bound_lo = '0, bound_hi = '0;
    logic        fault = 1'b0;
    logic        out_valid, wb_en, bnd_err;
    logic [31:0] ea, wb_data;
    logic [4:0]  wb_idx;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Expected values for the request driven on the previous cycle
    bit          pend = 0;
    string       p_tag;
    bit          x_valid, x_wbe, x_err;
    logic [31:0] x_ea, x_wbd;
    logic [4:0]  x_idx;

    always #5 clk = ~clk;

    eagu_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .base_sel(base_sel), .base_val(base_val), .index_val(index_val),
        .imm(imm), .next_pc(next_pc), .size_code(size_code),
        .bound_lo(bound_lo), .bound_hi(bound_hi), .fault(fault),
        .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .bnd_err(bnd_err)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_pending();
        if (pend) begin
            check(x_valid ? p_tag : "R2", "out_valid", 32'(out_valid), 32'(x_valid));
            if (x_valid) begin
                check(p_tag, "ea", ea, x_ea);
                check(p_tag, "wb_en", 32'(wb_en), 32'(x_wbe));
                check(p_tag, "bnd_err", 32'(bnd_err), 32'(x_err));
                if (x_wbe) begin
                    check(p_tag, "wb_data", wb_data, x_wbd);
                    check("R13", "wb_idx", 32'(wb_idx), 32'(x_idx));
                end
            end
        end
    endtask

    // Behavioural reference using wide signed arithmetic
    task automatic model();
        longint b, i, sx, sc, r, w;
        b  = (base_sel == 0) ? 0 : longint'(base_val);
        i  = longint'(index_val);
        sx = imm[15] ? longint'(imm[15:0]) - 65536 : longint'(imm[15:0]);
        sc = 2 ** size_code;
        r = 0; w = 0;
        x_wbe = 0; x_err = 0;
        case (mode)
            0: r = longint'(imm);
            1: r = longint'(next_pc) + sx;
            2: r = b;
            3: r = b + sx;
            4: r = b + i;
            5: r = b + i + sx;
            6: r = b + i * sc;
            7: begin r = b; w = b + sc; x_wbe = 1; end
            8: begin w = b - sc; r = w; x_wbe = 1; end
            9: begin
                r = b + i * sc;
                x_err = (index_val < bound_lo) || (index_val > bound_hi);
            end
            default: r = 0;
        endcase
        if (fault || base_sel == 0) x_wbe = 0;
        x_ea  = r[31:0];
        x_wbd = w[31:0];
        x_idx = base_sel;
    endtask

    task automatic issue(string tag, logic [3:0] m, logic [4:0] sel, logic [31:0] b,
                         logic [31:0] ix, logic [31:0] im, logic [31:0] pc,
                         logic [1:0] sz, logic [31:0] lo, logic [31:0] hi, logic f);
        @(negedge clk);
        compare_pending();
        req_valid = 1; mode = m; base_sel = sel; base_val = b; index_val = ix;
        imm = im; next_pc = pc; size_code = sz; bound_lo = lo; bound_hi = hi; fault = f;
        model();
        x_valid = 1; p_tag = tag; pend = 1;
    endtask

    task automatic idle();
        @(negedge clk);
        compare_pending();
        req_valid = 0; mode = 4'd7; fault = 0; base_sel = 5'd3;
        x_valid = 0; p_tag = "R2"; pend = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check("R1", "out_valid", 32'(out_valid), 0);
        check("R1", "wb_en", 32'(wb_en), 0);
        check("R1", "bnd_err", 32'(bnd_err), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "out_valid_after", 32'(out_valid), 0);

        issue("R3", 0, 5, 32'h1111_2222, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
        issue("R4", 1, 5, 0, 0, 32'h0000_8000, 32'h0000_1000, 0, 0, 0, 0);
        issue("R4", 1, 5, 0, 0, 32'hFFFF_7FFF, 32'h0000_1000, 0, 0, 0, 0);
        issue("R3", 2, 9, 32'hCAFE_0000, 0, 0, 0, 0, 0, 0, 0);
        issue("R5", 3, 9, 32'h0000_0010, 0, 32'h0000_FFE0, 0, 0, 0, 0, 0);
        issue("R6", 3, 0, 32'h7777_7777, 0, 32'h0000_8000, 0, 0, 0, 0, 0);
        issue("R6", 2, 0, 32'h7777_7777, 0, 0, 0, 0, 0, 0, 0);
        issue("R3", 4, 2, 32'h0000_1000, 32'h0000_0234, 0, 0, 0, 0, 0, 0);
        issue("R5", 5, 2, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0000_0004, 0, 0, 0, 0, 0);
        issue("R7", 6, 2, 32'h0000_1000, 32'h0000_0003, 0, 0, 3, 0, 0, 0);
        issue("R7", 6, 2, 32'h0000_1000, 32'h0000_0003, 0, 0, 1, 0, 0, 0);
        issue("R8", 7, 4, 32'h0000_2000, 0, 0, 0, 2, 0, 0, 0);
        issue("R8", 7, 4, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
        issue("R9", 8, 4, 32'h0000_2000, 0, 0, 0, 3, 0, 0, 0);
        issue("R9", 8, 4, 32'h0000_0001, 0, 0, 0, 1, 0, 0, 0);
        // R11: fault coinciding with auto-modify
        issue("R11", 7, 4, 32'h0000_3000, 0, 0, 0, 2, 0, 0, 1);
        issue("R11", 8, 4, 32'h0000_3000, 0, 0, 0, 2, 0, 0, 1);
        // R13: register zero with auto-modify
        issue("R13", 7, 0, 32'h0000_5000, 0, 0, 0, 2, 0, 0, 0);
        issue("R13", 8, 0, 32'h0000_5000, 0, 0, 0, 2, 0, 0, 0);
        // R10: bounds inside, edges, below, above
        issue("R10", 9, 6, 32'h0000_4000, 32'd5, 0, 0, 2, 32'd2, 32'd9, 0);
        issue("R10", 9, 6, 32'h0000_4000, 32'd2, 0, 0, 2, 32'd2, 32'd9, 0);
        issue("R10", 9, 6, 32'h0000_4000, 32'd9, 0, 0, 2, 32'd2, 32'd9, 0);
        issue("R10", 9, 6, 32'h0000_4000, 32'd1, 0, 0, 2, 32'd2, 32'd9, 0);
        issue("R10", 9, 6, 32'h0000_4000, 32'd10, 0, 0, 3, 32'd2, 32'd9, 0);
        issue("R12", 12, 6, 32'h0000_4000, 32'd10, 32'h55, 32'h99, 3, 32'd2, 32'd9, 0);
        issue("R12", 15, 6, 32'h0000_4000, 32'd10, 32'h55, 32'h99, 3, 32'd2, 32'd9, 0);
        idle();
        idle();
        issue("R2", 7, 4, 32'h0000_0100, 0, 0, 0, 0, 0, 0, 0);
        idle();

        for (int k = 0; k < 400; k++) begin
            if (($urandom % 5) == 0) idle();
            else issue("R5", 4'($urandom % 16), 5'($urandom % 4), $urandom, $urandom % 64,
                       $urandom, $urandom, 2'($urandom), $urandom % 16, 16 + $urandom % 32,
                       ($urandom % 3) == 0);
        end
        idle();
        @(negedge clk);
        compare_pending();
        pend = 0;

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule